// File: doc/BRIEF.md
# Outbound Window Enable Decoder

This block decides, for every memory request a CPU issues into the top 256 MiB of the address map, whether that request is passed on to a downstream bus. That region is cut into 32 fixed slices of 8 MiB each. Each slice has its own enable bit in a window-enable register. A two-bit mode field in a control register switches forwarding on or off for all slices at once. Both registers are written and read back through a small register port. The lowest slice and the highest slice can never be enabled.

In the other direction, the block sorts addresses issued by downstream bus masters into four classes: system memory, downstream memory, CPU-local space, or no target. Another unit uses that class to route the master's request. The block only makes the decision. It moves no data and gives no error responses.

Top module: `owd_top`

## Requirements
- R1: For a CPU address at or above 0xF000_0000, `fwd_window` reports the slice index (address − 0xF000_0000) / 0x80_0000, in the range 0 to 31. Below that base it reports 0.
- R2: A write to the window-enable register (`reg_sel`=0) stores the written value with bit 0 and bit 31 forced to zero. Those two bits always read back as zero.
- R3: Forwarding is active only while bits [8:7] of the control register (`reg_sel`=1) hold exactly 2'b01. With any other value, no slice produces a hit.
- R4: `fwd_hit` is 1 only when `cpu_req_valid` is 1, forwarding is active, the address is at or above 0xF000_0000, and the enable bit of its slice is set. While `fwd_hit` is 1, `fwd_addr` equals `cpu_req_addr`; otherwise `fwd_addr` is 0.
- R5: A valid master address below 0xF080_0000 gives `mst_target` = 2'b01 (system memory).
- R6: A valid master address from 0xF080_0000 up to 0xFF7F_FFFF gives `mst_target` = 2'b10 (downstream memory).
- R7: A valid master address from 0xFFF0_0000 up to 0xFFFF_FFFE gives `mst_target` = 2'b11 (CPU-local space).
- R8: `mst_target` is 2'b00 (no target) when `mst_req_valid` is 0, and for master addresses 0xFF80_0000 to 0xFFEF_FFFF and 0xFFFF_FFFF.
- R9: A register write on a clock edge changes the decode from the next cycle on. A request in the same cycle as the write is decoded with the old state. `reg_rdata` shows the register picked by `reg_sel` in the same cycle, without delay.
- R10: After a synchronous reset, both registers read as zero and no CPU address is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the register picked by `reg_sel` |
| reg_sel | input | 1 | Register select: 0 window enable, 1 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_addr | input | 32 | CPU request address |
| fwd_hit | output | 1 | Request is forwarded downstream |
| fwd_addr | output | 32 | Forwarded address (0 when no hit) |
| fwd_window | output | 5 | Slice index of the CPU address |
| mst_req_valid | input | 1 | Downstream master request present |
| mst_addr | input | 32 | Downstream master address |
| mst_target | output | 2 | Master class: 00 none, 01 system, 10 downstream, 11 CPU-local |

## Verification
The assertions check on every cycle that a hit only occurs with the mode field at 01 and the slice's enable bit set, and that the forwarded address is the request address. They also check that the register contents after a write follow the written data with the guard bits cleared, that system-memory addresses are always classified as such, and that the state is empty when reset ends. The bench's scenarios are needed for the rest: the exact slice boundaries, the gaps in the master map (including the top address 0xFFFF_FFFF), the mode values 00, 10 and 11, and whether a request in the same cycle as a write sees the old or the new state. These checks compare against a reference model cycle by cycle.

// File: rtl/owd_pkg.sv
package owd_pkg;

    localparam int ADDR_W        = 32;
    localparam int WIN_NUM       = 32;
    localparam int WIN_IDX_W     = $clog2(WIN_NUM);
    localparam int WIN_SPAN_LOG2 = 23;
    localparam int REGION_LSB    = WIN_SPAN_LOG2 + WIN_IDX_W;
    localparam int MODE_LSB      = 7;
    localparam int MODE_W        = 2;

    localparam logic [ADDR_W-1:0] REGION_BASE = 32'hF000_0000;
    localparam logic [ADDR_W-1:0] SYS_LIMIT   = 32'hF080_0000;
    localparam logic [ADDR_W-1:0] DS_LIMIT    = 32'hFF80_0000;
    localparam logic [ADDR_W-1:0] LOCAL_FIRST = 32'hFFF0_0000;
    localparam logic [ADDR_W-1:0] LOCAL_LAST  = 32'hFFFF_FFFE;
    localparam logic [MODE_W-1:0] MODE_ON     = 2'b01;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'b00,
        TGT_SYSMEM = 2'b01,
        TGT_DSMEM  = 2'b10,
        TGT_LOCAL  = 2'b11
    } tgt_e;

    typedef enum logic {
        SEL_WINEN = 1'b0,
        SEL_CTRL  = 1'b1
    } regsel_e;

    typedef struct packed {
        logic [WIN_NUM-1:0] win_en;
        logic [ADDR_W-1:0]  ctrl;
    } cfg_t;

    // Slices that may never be enabled: the first and the last.
    function automatic logic [WIN_NUM-1:0] keep_mask();
        logic [WIN_NUM-1:0] m;
        m = '1;
        m[0] = 1'b0;
        m[WIN_NUM-1] = 1'b0;
        return m;
    endfunction

    function automatic logic fwd_active(input logic [ADDR_W-1:0] ctrl);
        return ctrl[MODE_LSB +: MODE_W] == MODE_ON;
    endfunction

    function automatic logic in_region(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:REGION_LSB] == REGION_BASE[ADDR_W-1:REGION_LSB];
    endfunction

endpackage

// File: rtl/owd_cfg_regs.sv
module owd_cfg_regs
    import owd_pkg::*;
#(
    parameter int AW = owd_pkg::ADDR_W,
    parameter int NW = owd_pkg::WIN_NUM
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  regsel_e       sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] rd_data,
    output logic [NW-1:0] win_en_q,
    output logic [AW-1:0] ctrl_q
);

    localparam logic [NW-1:0] KEEP = keep_mask();

    always_ff @(posedge clk) begin
        if (rst) begin
            win_en_q <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            if (sel == SEL_WINEN) begin
                win_en_q <= wr_data[NW-1:0] & KEEP;
            end else begin
                ctrl_q <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_WINEN: rd_data[NW-1:0] = win_en_q;
            SEL_CTRL:  rd_data         = ctrl_q;
        endcase
    end

endmodule

// File: rtl/owd_cpu_window.sv
module owd_cpu_window
    import owd_pkg::*;
#(
    parameter int AW = owd_pkg::ADDR_W,
    parameter int NW = owd_pkg::WIN_NUM,
    parameter int IW = $clog2(NW),
    parameter int SPAN_LOG2 = owd_pkg::WIN_SPAN_LOG2
) (
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [NW-1:0] win_en,
    input  logic [AW-1:0] ctrl,
    output logic          hit,
    output logic [AW-1:0] out_addr,
    output logic [IW-1:0] window
);

    logic          region;
    logic          active;
    logic [IW-1:0] idx;
    logic [NW-1:0] slice_hit;

    assign region = in_region(req_addr);
    assign active = fwd_active(ctrl);
    assign idx    = req_addr[SPAN_LOG2 +: IW];

    // One comparator per slice; at most one can fire.
    for (genvar g = 0; g < NW; g++) begin : g_slice
        assign slice_hit[g] = region && (idx == IW'(g)) && win_en[g];
    end

    assign hit      = req_valid && active && (|slice_hit);
    assign out_addr = hit ? req_addr : '0;
    assign window   = region ? idx : '0;

endmodule

// File: rtl/owd_master_map.sv
module owd_master_map
    import owd_pkg::*;
#(
    parameter int AW = owd_pkg::ADDR_W
) (
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output tgt_e          target
);

    always_comb begin
        target = TGT_NONE;
        if (req_valid) begin
            if (req_addr < SYS_LIMIT) begin
                target = TGT_SYSMEM;
            end else if (req_addr < DS_LIMIT) begin
                target = TGT_DSMEM;
            end else if (req_addr >= LOCAL_FIRST && req_addr <= LOCAL_LAST) begin
                target = TGT_LOCAL;
            end
        end
    end

endmodule

// File: rtl/owd_top.sv
module owd_top
    import owd_pkg::*;
#(
    parameter int AW = owd_pkg::ADDR_W,
    parameter int NW = owd_pkg::WIN_NUM,
    parameter int IW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr_en,
    input  logic          reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          cpu_req_valid,
    input  logic [AW-1:0] cpu_req_addr,
    output logic          fwd_hit,
    output logic [AW-1:0] fwd_addr,
    output logic [IW-1:0] fwd_window,
    input  logic          mst_req_valid,
    input  logic [AW-1:0] mst_addr,
    output logic [1:0]    mst_target
);

    cfg_t    cfg;
    tgt_e    tgt;
    regsel_e sel;

    assign sel = regsel_e'(reg_sel);

    owd_cfg_regs #(.AW(AW), .NW(NW)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .sel      (sel),
        .wr_data  (reg_wdata),
        .rd_data  (reg_rdata),
        .win_en_q (cfg.win_en),
        .ctrl_q   (cfg.ctrl)
    );

    owd_cpu_window #(.AW(AW), .NW(NW), .IW(IW)) i_win (
        .req_valid (cpu_req_valid),
        .req_addr  (cpu_req_addr),
        .win_en    (cfg.win_en),
        .ctrl      (cfg.ctrl),
        .hit       (fwd_hit),
        .out_addr  (fwd_addr),
        .window    (fwd_window)
    );

    owd_master_map #(.AW(AW)) i_map (
        .req_valid (mst_req_valid),
        .req_addr  (mst_addr),
        .target    (tgt)
    );

    assign mst_target = tgt;

endmodule

// File: rtl/owd_checker.sv
module owd_checker
    import owd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          reg_wr_en,
    input logic          reg_sel,
    input logic [31:0]   reg_wdata,
    input logic          cpu_req_valid,
    input logic [31:0]   cpu_req_addr,
    input logic          fwd_hit,
    input logic [31:0]   fwd_addr,
    input logic          mst_req_valid,
    input logic [31:0]   mst_addr,
    input logic [1:0]    mst_target,
    input logic [31:0]   win_en,
    input logic [31:0]   ctrl
);

    a_r2_guard_mask: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_sel == 1'b0) |=> win_en == ($past(reg_wdata) & 32'h7FFF_FFFE));

    a_r9_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_sel == 1'b1) |=> ctrl == $past(reg_wdata));

    a_r3_mode_gate: assert property (@(posedge clk) disable iff (rst)
        fwd_hit |-> ctrl[8:7] == 2'b01);

    a_r4_slice_enabled: assert property (@(posedge clk) disable iff (rst)
        fwd_hit |-> (cpu_req_valid && cpu_req_addr[31:28] == 4'hF && win_en[cpu_req_addr[27:23]]));

    a_r4_addr_pass: assert property (@(posedge clk) disable iff (rst)
        fwd_hit |-> fwd_addr == cpu_req_addr);

    a_r5_sysmem: assert property (@(posedge clk) disable iff (rst)
        (mst_req_valid && mst_addr < 32'hF080_0000) |-> mst_target == 2'b01);

    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !mst_req_valid |-> mst_target == 2'b00);

    a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (win_en == 32'h0 && ctrl == 32'h0 && !fwd_hit));

endmodule

bind owd_top owd_checker i_owd_checker (
    .clk           (clk),
    .rst           (rst),
    .reg_wr_en     (reg_wr_en),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_addr  (cpu_req_addr),
    .fwd_hit       (fwd_hit),
    .fwd_addr      (fwd_addr),
    .mst_req_valid (mst_req_valid),
    .mst_addr      (mst_addr),
    .mst_target    (mst_target),
    .win_en        (cfg.win_en),
    .ctrl          (cfg.ctrl)
);

// File: tb/test_owd_top.sv
module test_owd_top;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_req_valid = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic        fwd_hit;
    logic [31:0] fwd_addr;
    logic [4:0]  fwd_window;
    logic        mst_req_valid = 1'b0;
    logic [31:0] mst_addr = '0;
    logic [1:0]  mst_target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state
    logic [31:0] m_en = '0;
    logic [31:0] m_ctrl = '0;

    always #(PERIOD/2) clk = ~clk;

    owd_top i_owd_top (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_req_valid(cpu_req_valid), .cpu_req_addr(cpu_req_addr),
        .fwd_hit(fwd_hit), .fwd_addr(fwd_addr), .fwd_window(fwd_window),
        .mst_req_valid(mst_req_valid), .mst_addr(mst_addr), .mst_target(mst_target)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        longint unsigned a;
        longint unsigned m;
        int slice;
        logic exp_hit;
        logic [1:0] exp_tgt;
        string ttag;
        a = longint'(cpu_req_addr);
        slice = (a >= 64'hF000_0000) ? int'((a - 64'hF000_0000) / 64'h80_0000) : 0;
        exp_hit = cpu_req_valid && (m_ctrl[8:7] == 2'b01) && (a >= 64'hF000_0000) && m_en[slice];
        chk("R9 readback", reg_rdata, reg_sel ? m_ctrl : m_en);
        chk(m_ctrl[8:7] == 2'b01 ? "R4 hit" : "R3 hit", {31'b0, fwd_hit}, {31'b0, exp_hit});
        chk("R4 addr", fwd_addr, exp_hit ? cpu_req_addr : 32'h0);
        chk("R1 window", {27'b0, fwd_window}, 32'(slice));
        m = longint'(mst_addr);
        if (!mst_req_valid) begin exp_tgt = 2'b00; ttag = "R8 target"; end
        else if (m < 64'hF080_0000) begin exp_tgt = 2'b01; ttag = "R5 target"; end
        else if (m < 64'hFF80_0000) begin exp_tgt = 2'b10; ttag = "R6 target"; end
        else if (m >= 64'hFFF0_0000 && m < 64'hFFFF_FFFF) begin exp_tgt = 2'b11; ttag = "R7 target"; end
        else begin exp_tgt = 2'b00; ttag = "R8 target"; end
        chk(ttag, {30'b0, mst_target}, {30'b0, exp_tgt});
    endtask

    task automatic cyc(input logic wr, input logic sel, input logic [31:0] wd,
                       input logic cv, input logic [31:0] ca,
                       input logic mv, input logic [31:0] ma);
        @(negedge clk);
        reg_wr_en = wr; reg_sel = sel; reg_wdata = wd;
        cpu_req_valid = cv; cpu_req_addr = ca;
        mst_req_valid = mv; mst_addr = ma;
        #1;
        compare_all();
        @(posedge clk);
        if (wr) begin
            if (!sel) m_en = wd & 32'h7FFF_FFFE;
            else m_ctrl = wd;
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] wd);
        cyc(1'b1, sel, wd, 1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic cpu(input logic [31:0] a);
        cyc(1'b0, 1'b0, 32'h0, 1'b1, a, 1'b0, 32'h0);
    endtask

    task automatic mst(input logic [31:0] a);
        cyc(1'b0, 1'b1, 32'h0, 1'b0, 32'h0, 1'b1, a);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        reg_sel = 1'b0; #1; chk("R10 enable reg", reg_rdata, 32'h0);
        reg_sel = 1'b1; #1; chk("R10 control reg", reg_rdata, 32'h0);
        cpu(32'hF080_0000);

        // R2: guard bits dropped; R3 still off
        wr_reg(1'b0, 32'hFFFF_FFFF);
        cyc(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
        cpu(32'hF100_0000);

        // R9: write and request in same cycle sees old state
        cyc(1'b1, 1'b1, 32'h0000_0080, 1'b1, 32'hF100_0000, 1'b0, 32'h0);
        cpu(32'hF100_0000);

        // R1/R4 slice boundaries
        cpu(32'hF000_0000);
        cpu(32'hF07F_FFFF);
        cpu(32'hF080_0000);
        cpu(32'hFF7F_FFFF);
        cpu(32'hFF80_0000);
        cpu(32'hFFFF_FFFF);
        cpu(32'hEFFF_FFFF);
        cpu(32'h1234_5678);
        cyc(1'b0, 1'b0, 32'h0, 1'b0, 32'hF100_0000, 1'b0, 32'h0);

        // R3: other mode values
        wr_reg(1'b1, 32'h0000_0180); cpu(32'hF100_0000);
        wr_reg(1'b1, 32'h0000_0100); cpu(32'hF100_0000);
        wr_reg(1'b1, 32'h0000_0000); cpu(32'hF100_0000);
        wr_reg(1'b1, 32'hFFFF_FE7F & 32'hFFFF_FEFF | 32'h80); cpu(32'hF100_0000);

        // R4: sparse enable pattern
        wr_reg(1'b0, 32'h0000_0404);
        for (int i = 0; i < 32; i++) cpu(32'hF000_0000 + i * 32'h80_0000 + 32'h1234);

        // R5..R8 master map edges
        mst(32'h0000_0000); mst(32'hF07F_FFFF); mst(32'hF080_0000);
        mst(32'hFF7F_FFFF); mst(32'hFF80_0000); mst(32'hFFEF_FFFF);
        mst(32'hFFF0_0000); mst(32'hFFFF_FFFE); mst(32'hFFFF_FFFF);
        cyc(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'hFFF0_0000);

        // Mixed traffic
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[3:0] == 4'h0, r[4], $urandom | (r[5] ? 32'h80 : 32'h0),
                r[6], {4'hF, 28'($urandom)} ^ (r[7] ? 32'h8000_0000 : 32'h0),
                r[8], r[9] ? {8'hFF, 24'($urandom)} : $urandom);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule